// File: doc/BRIEF.md
# Video Beam Position Interrupt Unit

This unit tracks where a raster scan currently is and raises an interrupt when the scan reaches points that software has programmed. A horizontal counter advances once per clock across a halfline, and its length is set through a register in steps of 16 clocks. A vertical counter advances once per halfline and wraps at a programmable frame length. Software can read back the current position at any time through the same register port.

Four compare slots each hold a target vertical and horizontal position, an enable, and a latched status flag. A slot's flag is set when the running raster reaches its target. The flag stays set until software writes the slot with the status bit clear. The single interrupt output is high whenever any slot has both its flag and its enable set.

A configuration register starts and stops the raster. It also holds a hold-in-reset bit, a scan-type bit and a two-bit video format code. While the raster is stopped or held in reset, both counters sit at zero and no flag can be set. All registers sit on a simple 32-bit word-indexed bus. Writes take effect on the clock edge, and reads are combinational.

Top module: `vbeam_irq_unit`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero, the position reads zero and `irq_o` is low.
- R2: The configuration word sits at index 0. Bit 0 is run, bit 1 is hold-in-reset, bit 2 is scan type (0 interlaced, 1 progressive), and bits 9:8 are the format code (0 NTSC, 1 PAL, 2 MPAL, 3 debug). Only these bits read back; all other bits read zero.
- R3: While run is 0 or hold-in-reset is 1, both counters are zero from the next edge on, and the position reads zero.
- R4: Index 1 holds the halfline width field W in bits 8:0, and index 2 holds the frame length F in halflines in bits 9:0. Both read back. A field value of 0 counts as 1. Once running, the horizontal count steps 0 to 16·W−1 one per clock, then returns to 0 and steps the vertical count. The vertical count wraps from F−1 to 0.
- R5: The read-only position word at index 3 carries the vertical count in bits 25:16 and the horizontal count in bits 12:0. Writes to index 3 have no effect.
- R6: Compare slots sit at indices 4 to 7. Each has status in bit 31, enable in bit 28, target vertical position in bits 25:16 and target horizontal position in bits 9:0, and reads back in that layout. A slot's status becomes 1 one edge after a running cycle in which both counts equal its targets.
- R7: A slot write with bit 31 = 0 clears its status, and a write with bit 31 = 1 leaves the status unchanged. The enable and target fields are loaded on every write. A match in the same cycle as a write takes priority over the clear.
- R8: No status is set while the raster is stopped or held in reset. A status that is already set is kept while the raster is stopped.
- R9: `irq_o` is the OR over the four slots of status AND enable, with no added delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe for the word at `bus_addr` |
| bus_addr | input | 3 | Word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq_o | output | 1 | Combined beam-position interrupt |

## Verification
The hardest situation to reach from the ports is a status flag set at an exact beam position. Checking it needs the bench to know the counter phase down to the cycle, for halfline widths and frame lengths that vary between trials, including zero fields and targets beyond the frame. The bench records the edge on which the run bit lands. From that edge and the programmed sizes it derives the expected position and the first cycle at which each target is reached. It then waits a random number of cycles, sometimes less than one frame and sometimes more than two, before comparing. The clear-versus-keep and enable-masking cases are checked with directed writes after the raster is stopped. This keeps flags from being set again while those writes are checked.

// File: rtl/vbeam_pkg.sv
// Package: shared widths, register indices, configuration type and the
// slot read-word builder for the beam position interrupt unit.
package vbeam_pkg;

    localparam int DATA_W     = 32;
    localparam int FIELD_W    = 10;   // width of position fields in words
    localparam int ST_BIT     = 31;   // slot status bit
    localparam int EN_BIT     = 28;   // slot enable bit
    localparam int TV_LSB     = 16;   // slot target vertical LSB

    localparam int IDX_CFG    = 0;
    localparam int IDX_HTIM   = 1;
    localparam int IDX_VTIM   = 2;
    localparam int IDX_POS    = 3;
    localparam int IDX_SLOT0  = 4;

    typedef enum logic [1:0] {
        FMT_NTSC  = 2'd0,
        FMT_PAL   = 2'd1,
        FMT_MPAL  = 2'd2,
        FMT_DEBUG = 2'd3
    } vfmt_e;

    typedef struct packed {
        vfmt_e fmt;
        logic  progressive;
        logic  hold_rst;
        logic  enable;
    } cfg_t;

    // Build the 32-bit read word of one compare slot.
    function automatic logic [DATA_W-1:0] slot_word_fn(
        input logic               st,
        input logic               en,
        input logic [FIELD_W-1:0] tv,
        input logic [FIELD_W-1:0] th
    );
        logic [DATA_W-1:0] w;
        w = '0;
        w[ST_BIT] = st;
        w[EN_BIT] = en;
        w[TV_LSB +: FIELD_W] = tv;
        w[0 +: FIELD_W] = th;
        return w;
    endfunction

    // Build the 32-bit read word of the configuration register.
    function automatic logic [DATA_W-1:0] cfg_word_fn(input cfg_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[9:8] = c.fmt;
        w[2]   = c.progressive;
        w[1]   = c.hold_rst;
        w[0]   = c.enable;
        return w;
    endfunction

endpackage

// File: rtl/vbeam_cfg_regs.sv
// Module: vbeam_cfg_regs
// Holds the configuration, halfline width and frame length registers and
// derives the run qualifier and effective counter limits.
// Assumes: write strobes are already decoded; a zero width or length field
// is treated as one unit so the counters always have a legal limit.
module vbeam_cfg_regs
    import vbeam_pkg::*;
#(
    parameter int HW_W   = 9,
    parameter int VCNT_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_cfg_i,
    input  logic              we_htim_i,
    input  logic              we_vtim_i,
    input  cfg_t              wr_cfg_i,
    input  logic [HW_W-1:0]   wr_hw_i,
    input  logic [VCNT_W-1:0] wr_vl_i,
    output cfg_t              cfg_o,
    output logic [HW_W-1:0]   hw_o,
    output logic [VCNT_W-1:0] vl_o,
    output logic              run_o,
    output logic [HW_W+3:0]   hlen_o,
    output logic [VCNT_W-1:0] flen_o
);

    cfg_t              cfg_q;
    logic [HW_W-1:0]   hw_q;
    logic [VCNT_W-1:0] vl_q;
    logic [HW_W-1:0]   hw_eff;

    // Purpose: load the configuration register on its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (we_cfg_i) begin
            cfg_q <= wr_cfg_i;
        end
    end

    // Purpose: load the halfline width field on its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hw_q <= '0;
        end else if (we_htim_i) begin
            hw_q <= wr_hw_i;
        end
    end

    // Purpose: load the frame length field on its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vl_q <= '0;
        end else if (we_vtim_i) begin
            vl_q <= wr_vl_i;
        end
    end

    // Purpose: derive run qualifier and the effective counter limits.
    always_comb begin
        hw_eff = (hw_q == '0) ? HW_W'(1) : hw_q;
        hlen_o = {hw_eff, 4'b0000};
        flen_o = (vl_q == '0) ? VCNT_W'(1) : vl_q;
        run_o  = cfg_q.enable && !cfg_q.hold_rst;
    end

    assign cfg_o = cfg_q;
    assign hw_o  = hw_q;
    assign vl_o  = vl_q;

endmodule

// File: rtl/vbeam_raster.sv
// Module: vbeam_raster
// Horizontal clock counter and vertical halfline counter of the raster.
// Assumes: hlen_i and flen_i are at least one; a limit that shrinks while
// running is handled by wrapping as soon as a count reaches or passes it.
module vbeam_raster #(
    parameter int HCNT_W = 13,
    parameter int VCNT_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic [HCNT_W-1:0] hlen_i,
    input  logic [VCNT_W-1:0] flen_i,
    output logic [HCNT_W-1:0] hpos_o,
    output logic [VCNT_W-1:0] vpos_o
);

    logic [HCNT_W-1:0] hpos_q;
    logic [VCNT_W-1:0] vpos_q;
    logic              h_last;
    logic              v_last;

    // Purpose: detect the last clock of a halfline and the last halfline.
    always_comb begin
        h_last = (hpos_q >= (hlen_i - 1'b1));
        v_last = (vpos_q >= (flen_i - 1'b1));
    end

    // Purpose: advance the counters while running, hold them at zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            hpos_q <= '0;
            vpos_q <= '0;
        end else if (h_last) begin
            hpos_q <= '0;
            vpos_q <= v_last ? '0 : (vpos_q + 1'b1);
        end else begin
            hpos_q <= hpos_q + 1'b1;
        end
    end

    assign hpos_o = hpos_q;
    assign vpos_o = vpos_q;

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (hpos_q == '0 && vpos_q == '0)); // R3
    AST_H_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !h_last) |=> (hpos_q == $past(hpos_q) + HCNT_W'(1)) && $stable(vpos_q)); // R4
    AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && h_last && v_last) |=> (hpos_q == '0 && vpos_q == '0)); // R4

endmodule

// File: rtl/vbeam_cmp_slot.sv
// Module: vbeam_cmp_slot
// One beam-position compare slot: target, enable and latched status.
// Assumes: each position lasts exactly one clock while running, so a match
// sets the status once per visit; a match outranks a clearing write.
module vbeam_cmp_slot #(
    parameter int HCNT_W  = 13,
    parameter int VCNT_W  = 10,
    parameter int TGT_H_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic               wr_keep_i,
    input  logic               wr_en_i,
    input  logic [VCNT_W-1:0]  wr_tv_i,
    input  logic [TGT_H_W-1:0] wr_th_i,
    input  logic               run_i,
    input  logic [HCNT_W-1:0]  hpos_i,
    input  logic [VCNT_W-1:0]  vpos_i,
    output logic               status_o,
    output logic               en_o,
    output logic [VCNT_W-1:0]  tv_o,
    output logic [TGT_H_W-1:0] th_o
);

    logic               status_q;
    logic               en_q;
    logic [VCNT_W-1:0]  tv_q;
    logic [TGT_H_W-1:0] th_q;
    logic               hit;

    // Purpose: compare the running raster against this slot's target.
    always_comb begin
        hit = run_i && (vpos_i == tv_q) && (hpos_i == HCNT_W'(th_q));
    end

    // Purpose: set status on a match, clear it on a write with the keep bit low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= 1'b0;
        end else if (hit) begin
            status_q <= 1'b1;
        end else if (wr_i && !wr_keep_i) begin
            status_q <= 1'b0;
        end
    end

    // Purpose: load enable and target fields on every slot write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
            tv_q <= '0;
            th_q <= '0;
        end else if (wr_i) begin
            en_q <= wr_en_i;
            tv_q <= wr_tv_i;
            th_q <= wr_th_i;
        end
    end

    assign status_o = status_q;
    assign en_o     = en_q;
    assign tv_o     = tv_q;
    assign th_o     = th_q;

    AST_HIT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> status_q); // R6
    AST_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !wr_keep_i && !hit) |=> !status_q); // R7
    AST_WR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && wr_keep_i && !hit) |=> $stable(status_q)); // R7
    AST_IDLE_NOSET: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !$rose(status_q)); // R8

endmodule

// File: rtl/vbeam_irq_unit.sv
// Module: vbeam_irq_unit (top)
// Raster position counter with beam-position compare slots on a 32-bit
// word-indexed register bus. Decodes writes, builds read words, and ORs
// the enabled slot flags into one interrupt line.
// Assumes: IDX_SLOT0 + N_SLOTS fits in the address space; reads are
// combinational and writes land on the clock edge.
module vbeam_irq_unit
    import vbeam_pkg::*;
#(
    parameter int ADDR_W  = 3,
    parameter int N_SLOTS = 4,
    parameter int HW_W    = 9,
    parameter int VCNT_W  = 10,
    parameter int TGT_H_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_o
);

    localparam int HCNT_W = HW_W + 4;

    logic              we_cfg;
    logic              we_htim;
    logic              we_vtim;
    cfg_t              wr_cfg;
    cfg_t              cfg_q;
    logic [HW_W-1:0]   hw_q;
    logic [VCNT_W-1:0] vl_q;
    logic              run;
    logic [HCNT_W-1:0] hlen;
    logic [VCNT_W-1:0] flen;
    logic [HCNT_W-1:0] hpos;
    logic [VCNT_W-1:0] vpos;
    logic [31:0]       pos_word;

    logic [N_SLOTS-1:0]            slot_we;
    logic [N_SLOTS-1:0]            slot_st;
    logic [N_SLOTS-1:0]            slot_en;
    logic [N_SLOTS-1:0][31:0]      slot_word;

    logic unused_wbits;
    assign unused_wbits = ^{bus_wdata[30:29], bus_wdata[27:26], bus_wdata[15:10]};

    // Purpose: decode the shared register strobes and configuration fields.
    always_comb begin
        we_cfg  = bus_we && (bus_addr == ADDR_W'(IDX_CFG));
        we_htim = bus_we && (bus_addr == ADDR_W'(IDX_HTIM));
        we_vtim = bus_we && (bus_addr == ADDR_W'(IDX_VTIM));
        wr_cfg.fmt         = vfmt_e'(bus_wdata[9:8]);
        wr_cfg.progressive = bus_wdata[2];
        wr_cfg.hold_rst    = bus_wdata[1];
        wr_cfg.enable      = bus_wdata[0];
    end

    vbeam_cfg_regs #(
        .HW_W   (HW_W),
        .VCNT_W (VCNT_W)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_cfg_i  (we_cfg),
        .we_htim_i (we_htim),
        .we_vtim_i (we_vtim),
        .wr_cfg_i  (wr_cfg),
        .wr_hw_i   (bus_wdata[HW_W-1:0]),
        .wr_vl_i   (bus_wdata[VCNT_W-1:0]),
        .cfg_o     (cfg_q),
        .hw_o      (hw_q),
        .vl_o      (vl_q),
        .run_o     (run),
        .hlen_o    (hlen),
        .flen_o    (flen)
    );

    vbeam_raster #(
        .HCNT_W (HCNT_W),
        .VCNT_W (VCNT_W)
    ) u_raster (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .hlen_i (hlen),
        .flen_i (flen),
        .hpos_o (hpos),
        .vpos_o (vpos)
    );

    for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
        logic [VCNT_W-1:0]  tv;
        logic [TGT_H_W-1:0] th;

        assign slot_we[i] = bus_we && (bus_addr == ADDR_W'(IDX_SLOT0 + i));

        vbeam_cmp_slot #(
            .HCNT_W  (HCNT_W),
            .VCNT_W  (VCNT_W),
            .TGT_H_W (TGT_H_W)
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_i      (slot_we[i]),
            .wr_keep_i (bus_wdata[ST_BIT]),
            .wr_en_i   (bus_wdata[EN_BIT]),
            .wr_tv_i   (bus_wdata[TV_LSB +: VCNT_W]),
            .wr_th_i   (bus_wdata[TGT_H_W-1:0]),
            .run_i     (run),
            .hpos_i    (hpos),
            .vpos_i    (vpos),
            .status_o  (slot_st[i]),
            .en_o      (slot_en[i]),
            .tv_o      (tv),
            .th_o      (th)
        );

        assign slot_word[i] = slot_word_fn(slot_st[i], slot_en[i],
                                           FIELD_W'(tv), FIELD_W'(th));
    end

    // Purpose: pack the live raster position into its read word.
    always_comb begin
        pos_word = '0;
        pos_word[TV_LSB +: VCNT_W] = vpos;
        pos_word[0 +: HCNT_W]      = hpos;
    end

    // Purpose: select the read word for the addressed register.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(IDX_CFG)) begin
            bus_rdata = cfg_word_fn(cfg_q);
        end else if (bus_addr == ADDR_W'(IDX_HTIM)) begin
            bus_rdata = 32'(hw_q);
        end else if (bus_addr == ADDR_W'(IDX_VTIM)) begin
            bus_rdata = 32'(vl_q);
        end else if (bus_addr == ADDR_W'(IDX_POS)) begin
            bus_rdata = pos_word;
        end else begin
            for (int s = 0; s < N_SLOTS; s++) begin
                if (bus_addr == ADDR_W'(IDX_SLOT0 + s)) begin
                    bus_rdata = slot_word[s];
                end
            end
        end
    end

    // Purpose: combine enabled, active slot flags into the interrupt line.
    assign irq_o = |(slot_st & slot_en);

    AST_IRQ_NEEDS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_st == '0) |-> !irq_o); // R9
    AST_POS_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (pos_word == '0)); // R3

endmodule

// File: tb/vbeam_irq_unit_bench.sv
`timescale 1ns/1ps
module vbeam_irq_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    vbeam_irq_unit u_vbeam_irq_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d, output int edge_no);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        edge_no = cyc;
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.2;
        d = bus_rdata;
    endtask

    task automatic waitcyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic logic [31:0] pos_exp(input int k, input int l, input int f);
        int h, v;
        h = k % l;
        v = (k / l) % f;
        return {6'b0, v[9:0], 3'b0, h[12:0]};
    endfunction

    function automatic logic st_exp(input int tv, input int th, input int l,
                                    input int f, input int k);
        if (tv >= f || th >= l) return 1'b0;
        return (tv * l + th) < k;
    endfunction

    function automatic logic [31:0] slot_exp(input logic st, input logic en,
                                             input int tv, input int th);
        return {st, 2'b0, en, 2'b0, tv[9:0], 6'b0, th[9:0]};
    endfunction

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int e, k;
        int tvs[4];
        int ths[4];
        logic ens[4];
        void'($urandom(32'h5eed_1234));

        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        waitcyc(2);

        // R1: reset state of every word and the interrupt
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            chk("R1", $sformatf("word %0d after reset", a), d, 32'h0);
        end
        chk("R1", "irq after reset", {31'b0, irq_o}, 32'h0);

        // R2: only defined configuration bits read back (hold bit set, run clear)
        wr(3'd0, 32'hFFFF_FFFE, e);
        rd(3'd0, d);
        chk("R2", "cfg readback mask", d, 32'h0000_0306);
        waitcyc(20);
        rd(3'd3, d);
        chk("R3", "position held while stopped", d, 32'h0);

        // R3/R8: run and hold both set; slot 0 targets (0,0) and stays clear
        wr(3'd4, 32'h1000_0000, e);
        wr(3'd0, 32'h0000_0003, e);
        waitcyc(30);
        rd(3'd3, d);
        chk("R3", "position held by hold bit", d, 32'h0);
        rd(3'd4, d);
        chk("R8", "no set while held", d, 32'h1000_0000);

        // R5: writes to position ignored
        wr(3'd0, 32'h0, e);
        wr(3'd3, 32'hFFFF_FFFF, e);
        rd(3'd3, d);
        chk("R5", "position write ignored", d, 32'h0);

        // Directed run: W=1 (16 clocks), F=4
        wr(3'd1, 32'h0000_0001, e);
        wr(3'd2, 32'h0000_0004, e);
        rd(3'd1, d);
        chk("R4", "width readback", d, 32'h1);
        rd(3'd2, d);
        chk("R4", "length readback", d, 32'h4);
        wr(3'd5, 32'h0002_0005, e);
        wr(3'd6, 32'h1003_000F, e);
        wr(3'd7, 32'h1004_0000, e);
        wr(3'd0, 32'h0000_0001, e);
        waitcyc(5);
        rd(3'd3, d);
        chk("R4", "position k=5", d, pos_exp(5, 16, 4));
        rd(3'd4, d);
        chk("R6", "slot0 set at frame start", d, 32'h9000_0000);
        rd(3'd5, d);
        chk("R6", "slot1 not yet", d, 32'h0002_0005);
        chk("R9", "irq from slot0", {31'b0, irq_o}, 32'h1);
        waitcyc(33);
        rd(3'd3, d);
        chk("R4", "position k=38", d, pos_exp(38, 16, 4));
        rd(3'd5, d);
        chk("R6", "slot1 set", d, 32'h8002_0005);
        rd(3'd6, d);
        chk("R6", "slot2 not yet", d, 32'h1003_000F);
        waitcyc(26);
        rd(3'd3, d);
        chk("R4", "frame wrap k=64", d, pos_exp(64, 16, 4));
        rd(3'd6, d);
        chk("R6", "slot2 set at last clock", d, 32'h9003_000F);
        rd(3'd7, d);
        chk("R6", "slot3 target beyond frame", d, 32'h1004_0000);

        // R7/R9: keep, clear, and enable masking with raster stopped
        wr(3'd0, 32'h0, e);
        wr(3'd4, 32'h9000_0000, e);
        rd(3'd4, d);
        chk("R7", "keep on bit31 set", d, 32'h9000_0000);
        wr(3'd4, 32'h1000_0000, e);
        rd(3'd4, d);
        chk("R7", "clear on bit31 low", d, 32'h1000_0000);
        wr(3'd6, 32'h1003_000F, e);
        rd(3'd5, d);
        chk("R8", "flag kept while stopped", d, 32'h8002_0005);
        chk("R9", "irq masked by enable", {31'b0, irq_o}, 32'h0);
        wr(3'd5, 32'h9002_0005, e);
        rd(3'd5, d);
        chk("R7", "enable loaded, status kept", d, 32'h9002_0005);
        chk("R9", "irq after enable", {31'b0, irq_o}, 32'h1);
        rd(3'd3, d);
        chk("R3", "position zero after stop", d, 32'h0);

        // Random trials
        for (int it = 0; it < 24; it++) begin
            int wf, ff, l, f, n;
            logic [1:0] fmt;
            logic scan;
            logic any;
            wf = $urandom % 4;
            ff = $urandom % 7;
            l = (wf == 0 ? 1 : wf) * 16;
            f = (ff == 0 ? 1 : ff);
            fmt = 2'($urandom);
            scan = 1'($urandom);
            wr(3'd0, 32'h0, e);
            for (int s = 0; s < 4; s++) begin
                tvs[s] = $urandom % (f + 2);
                ths[s] = $urandom % (l + 4);
                ens[s] = 1'($urandom);
                wr(3'(4 + s), slot_exp(1'b0, ens[s], tvs[s], ths[s]), e);
            end
            wr(3'd1, 32'(wf), e);
            wr(3'd2, 32'(ff), e);
            wr(3'd0, {22'b0, fmt, 5'b0, scan, 2'b01}, e);
            n = 1 + ($urandom % (2 * l * f + 3));
            waitcyc(n);
            k = n;
            rd(3'd3, d);
            chk("R4", $sformatf("random position it=%0d", it), d, pos_exp(k, l, f));
            any = 1'b0;
            for (int s = 0; s < 4; s++) begin
                logic st;
                st = st_exp(tvs[s], ths[s], l, f, k);
                any = any | (st & ens[s]);
                rd(3'(4 + s), d);
                chk("R6", $sformatf("random slot%0d it=%0d", s, it), d,
                    slot_exp(st, ens[s], tvs[s], ths[s]));
            end
            chk("R9", $sformatf("random irq it=%0d", it), {31'b0, irq_o}, {31'b0, any});
            rd(3'd0, d);
            chk("R2", $sformatf("random cfg it=%0d", it), d, {22'b0, fmt, 5'b0, scan, 2'b01});
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule